// File: doc/BRIEF.md
# Machine-Mode CSR and Trap Unit

This block holds the machine-level control and status registers of a 32-bit hart that runs only at the highest privilege level. The core reaches them through a CSR port with a 12-bit address. Reads are combinational. A write lands on the next rising clock edge. The port has no back-pressure: every request is served in the cycle it is presented.

The unit also sequences traps. It has three kinds of input:
- An exception request from the core, carrying a cause, the faulting PC and the instruction word.
- A separate strobe that records a fault address ahead of the exception.
- Three raw interrupt lines: software, timer and external.

From the enables and the global interrupt enable, the unit arbitrates one interrupt and offers it to the core as a take request. The core accepts it with an acknowledge that carries the next-instruction PC. On trap entry and on a trap return, the unit updates its registers and drives a redirect PC in the same cycle.

Top module: `mcsr_trap_unit`

## Requirements
- R1: Writes to the status register (0x300) keep only bit 3 (global enable), bit 7 (previous enable) and bits 12:11 (previous privilege), that is mask 0x00001888. All other bits read 0.
- R2: The interrupt-enable register (0x304) keeps only bits 3, 7 and 11 (mask 0x888). A read of the pending register (0x344) returns its software-written bits (same mask) ORed with the raw lines: software on bit 3, timer on bit 7, external on bit 11. Neither read is filtered by any other register.
- R3: The ID registers read fixed values and ignore writes: ISA word 0x40001104 at 0x301, vendor 0x669 at 0xF11, architecture 0x80000003 at 0xF12, implementation 1 at 0xF13.
- R4: `irq_take` is high only when the global enable is set and an enabled interrupt is pending. `irq_cause` then names the winner: external (11) first, then software (3), then timer (7).
- R5: When `exc_valid` is high, `redirect_pc` is the trap base in that same cycle. After the edge, the saved PC (0x341) holds `exc_pc` and the cause register (0x342) holds `exc_cause` with bit 31 clear.
- R6: When `irq_ack` is high while `irq_take` is high, the saved PC gets `irq_next_pc` and the cause register gets bit 31 set together with `irq_cause`. The redirect is base + 4*cause when bit 0 of the trap vector (0x305) is 1, and the plain base when it is 0. An acknowledge without `irq_take` is ignored.
- R7: For cause 2, the trap value register (0x343) gets the whole instruction word when its low two bits are 11. Otherwise it gets only the low 16 bits, zero extended.
- R8: For any other exception cause, the trap value register gets the recorded fault address. A record made in the same cycle is used. Every exception then clears the record to 0.
- R9: Trap entry copies the global enable into the previous enable, clears the global enable and sets the previous privilege to 11.
- R10: When `mret` is high, `redirect_pc` is the saved PC in that same cycle. After the edge, the global enable takes the previous enable, the previous enable becomes 1, and `irq_take` reflects the restored state from that next cycle on.
- R11: The trap vector register reads bit 1 as 0. The trap base is the vector with its low two bits forced to 0.
- R12: Priority within a cycle is exception over interrupt acknowledge, then trap return. A trap overrides a CSR write in the same cycle.
- R13: The scratch register (0x340) keeps all 32 bits written to it. Unmapped addresses read 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| csr_en | input | 1 | CSR access this cycle |
| csr_we | input | 1 | Access is a write |
| csr_addr | input | 12 | CSR address |
| csr_wdata | input | 32 | Write data |
| csr_rdata | output | 32 | Read data (combinational) |
| exc_valid | input | 1 | Exception entry request |
| exc_cause | input | 5 | Exception cause code |
| exc_pc | input | 32 | PC of the faulting instruction |
| exc_insn | input | 32 | Faulting instruction word |
| fault_rec_valid | input | 1 | Record a fault address |
| fault_rec_addr | input | 32 | Fault address to record |
| irq_sw | input | 1 | Raw software interrupt line |
| irq_tim | input | 1 | Raw timer interrupt line |
| irq_ext | input | 1 | Raw external interrupt line |
| irq_take | output | 1 | An enabled interrupt is ready |
| irq_cause | output | 5 | Cause of the winning interrupt |
| irq_ack | input | 1 | Core takes the offered interrupt |
| irq_next_pc | input | 32 | Next-instruction PC for the interrupt |
| mret | input | 1 | Trap return |
| redirect_valid | output | 1 | Redirect this cycle |
| redirect_pc | output | 32 | Redirect target |

## Verification
Read data, `redirect_valid`/`redirect_pc`, `irq_take` and `irq_cause` are combinational. They are due in the same cycle as the stimulus. Register effects of a write, trap entry or trap return become visible in the cycle after the next rising edge. The bench therefore drives every input just after a falling edge and samples combinational results 1 ns later, before the rising edge. It then reads back register state through the CSR port in a later cycle.

// File: rtl/mcsr_pkg.sv
package mcsr_pkg;
  localparam int XLEN    = 32;
  localparam int CAUSE_W = 5;
  localparam int ADDR_W  = 12;

  typedef logic [XLEN-1:0] word_t;

  localparam logic [ADDR_W-1:0] A_STATUS  = 12'h300;
  localparam logic [ADDR_W-1:0] A_ISA     = 12'h301;
  localparam logic [ADDR_W-1:0] A_IENA    = 12'h304;
  localparam logic [ADDR_W-1:0] A_TVEC    = 12'h305;
  localparam logic [ADDR_W-1:0] A_SCRATCH = 12'h340;
  localparam logic [ADDR_W-1:0] A_EPC     = 12'h341;
  localparam logic [ADDR_W-1:0] A_CAUSE   = 12'h342;
  localparam logic [ADDR_W-1:0] A_TVAL    = 12'h343;
  localparam logic [ADDR_W-1:0] A_IPEND   = 12'h344;
  localparam logic [ADDR_W-1:0] A_VENDOR  = 12'hF11;
  localparam logic [ADDR_W-1:0] A_ARCH    = 12'hF12;
  localparam logic [ADDR_W-1:0] A_IMPL    = 12'hF13;

  localparam word_t STATUS_KEEP = 32'h0000_1888;
  localparam word_t IRQ_KEEP    = 32'h0000_0888;
  localparam word_t PC_KEEP     = ~word_t'(1);

  localparam int B_GIE  = 3;
  localparam int B_PGIE = 7;
  localparam int B_PPRV = 11;

  localparam int NSRC = 3;
  // priority order, highest first: external, software, timer
  localparam int SRC_ORDER [NSRC] = '{11, 3, 7};

  localparam logic [CAUSE_W-1:0] CAUSE_ILLEGAL = 5'd2;

  function automatic word_t illegal_tval(input word_t insn);
    return (insn[1:0] == 2'b11) ? insn : {16'h0000, insn[15:0]};
  endfunction
endpackage

// File: rtl/mcsr_irq_arb.sv
module mcsr_irq_arb
  import mcsr_pkg::*;
(
  input  logic               gie,
  input  word_t              pend,
  input  word_t              ena,
  output logic               take,
  output logic [CAUSE_W-1:0] cause
);
  word_t active;
  assign active = gie ? (pend & ena & IRQ_KEEP) : '0;

  always_comb begin
    take  = 1'b0;
    cause = '0;
    // walk from lowest to highest priority so the highest wins
    for (int i = NSRC - 1; i >= 0; i--) begin
      if (active[SRC_ORDER[i]]) begin
        take  = 1'b1;
        cause = CAUSE_W'(SRC_ORDER[i]);
      end
    end
  end
endmodule

// File: rtl/mcsr_status.sv
module mcsr_status
  import mcsr_pkg::*;
(
  input  logic  clk,
  input  logic  rst_n,
  input  logic  wr_en,
  input  word_t wdata,
  input  logic  trap_enter,
  input  logic  trap_return,
  output word_t status
);
  word_t st_q;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      st_q <= '0;
    end else if (trap_enter) begin
      st_q[B_PGIE]            <= st_q[B_GIE];
      st_q[B_GIE]             <= 1'b0;
      st_q[B_PPRV+1:B_PPRV]   <= 2'b11;
    end else if (trap_return) begin
      st_q[B_GIE]             <= st_q[B_PGIE];
      st_q[B_PGIE]            <= 1'b1;
    end else if (wr_en) begin
      st_q <= wdata & STATUS_KEEP;
    end
  end

  assign status = st_q;

  AST_STATUS_MASKED: assert property (@(posedge clk) disable iff (!rst_n)
    wr_en && !trap_enter && !trap_return |=> (st_q & ~STATUS_KEEP) == '0); // R1
  AST_ENTRY_CLEARS_GIE: assert property (@(posedge clk) disable iff (!rst_n)
    trap_enter |=> !st_q[B_GIE] && st_q[B_PGIE] == $past(st_q[B_GIE])); // R9
  AST_RETURN_SETS_PGIE: assert property (@(posedge clk) disable iff (!rst_n)
    trap_return && !trap_enter |=> st_q[B_PGIE] && st_q[B_GIE] == $past(st_q[B_PGIE])); // R10
endmodule

// File: rtl/mcsr_trap_ctrl.sv
module mcsr_trap_ctrl
  import mcsr_pkg::*;
(
  input  logic               clk,
  input  logic               rst_n,
  input  logic               exc_valid,
  input  logic [CAUSE_W-1:0] exc_cause,
  input  word_t              exc_pc,
  input  word_t              exc_insn,
  input  logic               fault_rec_valid,
  input  word_t              fault_rec_addr,
  input  logic               irq_enter,
  input  logic [CAUSE_W-1:0] irq_cause,
  input  word_t              irq_next_pc,
  input  logic               ret_go,
  input  logic [XLEN-3:0]    tvec_base,
  input  logic               tvec_vectored,
  input  logic               wr_epc,
  input  logic               wr_cause,
  input  logic               wr_tval,
  input  word_t              wdata,
  output word_t              epc,
  output word_t              cause,
  output word_t              tval,
  output logic               redirect_valid,
  output word_t              redirect_pc
);
  localparam int PAD_W = XLEN - 1 - CAUSE_W;

  word_t epc_q, cause_q, tval_q, fault_q;
  word_t base_pc, fault_src;

  assign base_pc   = {tvec_base, 2'b00};
  assign fault_src = fault_rec_valid ? fault_rec_addr : fault_q;

  always_comb begin
    redirect_valid = exc_valid | irq_enter | ret_go;
    if (exc_valid)
      redirect_pc = base_pc;
    else if (irq_enter)
      redirect_pc = tvec_vectored ? base_pc + XLEN'({irq_cause, 2'b00}) : base_pc;
    else if (ret_go)
      redirect_pc = epc_q;
    else
      redirect_pc = '0;
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      epc_q   <= '0;
      cause_q <= '0;
      tval_q  <= '0;
      fault_q <= '0;
    end else if (exc_valid) begin
      epc_q   <= exc_pc & PC_KEEP;
      cause_q <= {1'b0, {PAD_W{1'b0}}, exc_cause};
      tval_q  <= (exc_cause == CAUSE_ILLEGAL) ? illegal_tval(exc_insn) : fault_src;
      fault_q <= '0;
    end else if (irq_enter) begin
      epc_q   <= irq_next_pc & PC_KEEP;
      cause_q <= {1'b1, {PAD_W{1'b0}}, irq_cause};
      if (fault_rec_valid) fault_q <= fault_rec_addr;
    end else begin
      if (wr_epc)          epc_q   <= wdata & PC_KEEP;
      if (wr_cause)        cause_q <= wdata;
      if (wr_tval)         tval_q  <= wdata;
      if (fault_rec_valid) fault_q <= fault_rec_addr;
    end
  end

  assign epc   = epc_q;
  assign cause = cause_q;
  assign tval  = tval_q;

  AST_EPC_ON_EXC: assert property (@(posedge clk) disable iff (!rst_n)
    exc_valid |=> epc_q == ($past(exc_pc) & PC_KEEP)); // R5
  AST_RECORD_CLEARED: assert property (@(posedge clk) disable iff (!rst_n)
    exc_valid |=> fault_q == '0); // R8
  AST_IRQ_CAUSE_FLAG: assert property (@(posedge clk) disable iff (!rst_n)
    irq_enter && !exc_valid |=> cause_q[XLEN-1]); // R6
endmodule

// File: rtl/mcsr_trap_unit.sv
module mcsr_trap_unit
  import mcsr_pkg::*;
#(
  parameter logic [31:0] ISA_WORD  = 32'h4000_1104,
  parameter logic [31:0] VENDOR_ID = 32'h0000_0669,
  parameter logic [31:0] ARCH_ID   = 32'h8000_0003,
  parameter logic [31:0] IMPL_ID   = 32'h0000_0001
) (
  input  logic                clk,
  input  logic                rst_n,
  input  logic                csr_en,
  input  logic                csr_we,
  input  logic [ADDR_W-1:0]   csr_addr,
  input  logic [XLEN-1:0]     csr_wdata,
  output logic [XLEN-1:0]     csr_rdata,
  input  logic                exc_valid,
  input  logic [CAUSE_W-1:0]  exc_cause,
  input  logic [XLEN-1:0]     exc_pc,
  input  logic [XLEN-1:0]     exc_insn,
  input  logic                fault_rec_valid,
  input  logic [XLEN-1:0]     fault_rec_addr,
  input  logic                irq_sw,
  input  logic                irq_tim,
  input  logic                irq_ext,
  output logic                irq_take,
  output logic [CAUSE_W-1:0]  irq_cause,
  input  logic                irq_ack,
  input  logic [XLEN-1:0]     irq_next_pc,
  input  logic                mret,
  output logic                redirect_valid,
  output logic [XLEN-1:0]     redirect_pc
);
  word_t ien_q, ipend_q, scratch_q, status, epc, cause, tval;
  logic [XLEN-3:0] tvec_base_q;
  logic tvec_vec_q;
  word_t raw_lines, pend_view;
  logic irq_enter, trap_any, ret_go, wr_any;

  assign raw_lines = word_t'({irq_ext, 3'b000, irq_tim, 3'b000, irq_sw, 3'b000});
  assign pend_view = (ipend_q | raw_lines) & IRQ_KEEP;

  assign irq_enter = irq_ack & irq_take & ~exc_valid;
  assign trap_any  = exc_valid | irq_enter;
  assign ret_go    = mret & ~trap_any;
  assign wr_any    = csr_en & csr_we & ~trap_any;

  mcsr_irq_arb u_arb (
    .gie   (status[B_GIE]),
    .pend  (pend_view),
    .ena   (ien_q),
    .take  (irq_take),
    .cause (irq_cause)
  );

  mcsr_status u_status (
    .clk         (clk),
    .rst_n       (rst_n),
    .wr_en       (wr_any && csr_addr == A_STATUS),
    .wdata       (csr_wdata),
    .trap_enter  (trap_any),
    .trap_return (ret_go),
    .status      (status)
  );

  mcsr_trap_ctrl u_trap (
    .clk             (clk),
    .rst_n           (rst_n),
    .exc_valid       (exc_valid),
    .exc_cause       (exc_cause),
    .exc_pc          (exc_pc),
    .exc_insn        (exc_insn),
    .fault_rec_valid (fault_rec_valid),
    .fault_rec_addr  (fault_rec_addr),
    .irq_enter       (irq_enter),
    .irq_cause       (irq_cause),
    .irq_next_pc     (irq_next_pc),
    .ret_go          (ret_go),
    .tvec_base       (tvec_base_q),
    .tvec_vectored   (tvec_vec_q),
    .wr_epc          (wr_any && csr_addr == A_EPC),
    .wr_cause        (wr_any && csr_addr == A_CAUSE),
    .wr_tval         (wr_any && csr_addr == A_TVAL),
    .wdata           (csr_wdata),
    .epc             (epc),
    .cause           (cause),
    .tval            (tval),
    .redirect_valid  (redirect_valid),
    .redirect_pc     (redirect_pc)
  );

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      ien_q       <= '0;
      ipend_q     <= '0;
      scratch_q   <= '0;
      tvec_base_q <= '0;
      tvec_vec_q  <= 1'b0;
    end else if (wr_any) begin
      case (csr_addr)
        A_IENA:    ien_q     <= csr_wdata & IRQ_KEEP;
        A_IPEND:   ipend_q   <= csr_wdata & IRQ_KEEP;
        A_SCRATCH: scratch_q <= csr_wdata;
        A_TVEC: begin
          tvec_base_q <= csr_wdata[XLEN-1:2];
          tvec_vec_q  <= csr_wdata[0];
        end
        default: ;
      endcase
    end
  end

  always_comb begin
    unique case (csr_addr)
      A_STATUS:  csr_rdata = status;
      A_ISA:     csr_rdata = ISA_WORD;
      A_IENA:    csr_rdata = ien_q;
      A_TVEC:    csr_rdata = {tvec_base_q, 1'b0, tvec_vec_q};
      A_SCRATCH: csr_rdata = scratch_q;
      A_EPC:     csr_rdata = epc;
      A_CAUSE:   csr_rdata = cause;
      A_TVAL:    csr_rdata = tval;
      A_IPEND:   csr_rdata = pend_view;
      A_VENDOR:  csr_rdata = VENDOR_ID;
      A_ARCH:    csr_rdata = ARCH_ID;
      A_IMPL:    csr_rdata = IMPL_ID;
      default:   csr_rdata = '0;
    endcase
  end

  AST_TAKE_NEEDS_GIE: assert property (@(posedge clk) disable iff (!rst_n)
    irq_take |-> status[B_GIE]); // R4
  AST_PEND_READ_MASKED: assert property (@(posedge clk) disable iff (!rst_n)
    csr_en && csr_addr == A_IPEND |-> (csr_rdata & ~IRQ_KEEP) == '0); // R2
  AST_REDIRECT_WITH_EVENT: assert property (@(posedge clk) disable iff (!rst_n)
    redirect_valid |-> exc_valid || irq_ack || mret); // R12
endmodule

// File: tb/tb_mcsr_trap_unit.sv
module tb_mcsr_trap_unit;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        csr_en = 0, csr_we = 0;
  logic [11:0] csr_addr = '0;
  logic [31:0] csr_wdata = '0, csr_rdata;
  logic        exc_valid = 0;
  logic [4:0]  exc_cause = '0;
  logic [31:0] exc_pc = '0, exc_insn = '0;
  logic        fault_rec_valid = 0;
  logic [31:0] fault_rec_addr = '0;
  logic        irq_sw = 0, irq_tim = 0, irq_ext = 0;
  logic        irq_take;
  logic [4:0]  irq_cause;
  logic        irq_ack = 0;
  logic [31:0] irq_next_pc = '0;
  logic        mret = 0;
  logic        redirect_valid;
  logic [31:0] redirect_pc;

  int n_chk = 0, n_bad = 0;
  bit done = 0;

  always #4 clk = ~clk; // 125 MHz

  mcsr_trap_unit dut (.*);

  task automatic chk(string tag, logic [31:0] act, logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  task automatic wr(logic [11:0] a, logic [31:0] d);
    @(negedge clk); csr_en = 1; csr_we = 1; csr_addr = a; csr_wdata = d;
    @(negedge clk); csr_en = 0; csr_we = 0;
  endtask

  task automatic rdchk(logic [11:0] a, logic [31:0] exp, string tag);
    @(negedge clk); csr_en = 1; csr_we = 0; csr_addr = a;
    #1 chk(tag, csr_rdata, exp);
    csr_en = 0;
  endtask

  task automatic raise_exc(logic [4:0] c, logic [31:0] pc, logic [31:0] insn,
                           logic [31:0] exp_pc, string tag);
    @(negedge clk); exc_valid = 1; exc_cause = c; exc_pc = pc; exc_insn = insn;
    #1 chk({tag, " redirect"}, redirect_pc, exp_pc);
    @(negedge clk); exc_valid = 0;
  endtask

  task automatic t_reset;
    rdchk(12'h300, 32'h0, "R1 status reset");
    rdchk(12'h304, 32'h0, "R2 enable reset");
    rdchk(12'h342, 32'h0, "R5 cause reset");
    rdchk(12'h7C0, 32'h0, "R13 unmapped read");
    chk("R4 no take at reset", {31'h0, irq_take}, 32'h0);
    chk("R12 no redirect at reset", {31'h0, redirect_valid}, 32'h0);
  endtask

  task automatic t_status_mask;
    wr(12'h300, 32'hFFFF_FFFF);
    rdchk(12'h300, 32'h0000_1888, "R1 status ones");
    wr(12'h300, 32'h0000_0000);
    rdchk(12'h300, 32'h0, "R1 status zero");
  endtask

  task automatic t_ids;
    for (int pass = 0; pass < 2; pass++) begin
      rdchk(12'h301, 32'h4000_1104, "R3 isa");
      rdchk(12'hF11, 32'h0000_0669, "R3 vendor");
      rdchk(12'hF12, 32'h8000_0003, "R3 arch");
      rdchk(12'hF13, 32'h0000_0001, "R3 impl");
      wr(12'h301, 32'h0); wr(12'hF11, 32'h0); wr(12'hF12, 32'h0); wr(12'hF13, 32'hFFFF_FFFF);
    end
  endtask

  task automatic t_irq_regs;
    wr(12'h304, 32'hFFFF_FFFF);
    rdchk(12'h304, 32'h0000_0888, "R2 enable mask");
    wr(12'h344, 32'hFFFF_FFFF);
    rdchk(12'h344, 32'h0000_0888, "R2 pending mask");
    wr(12'h344, 32'h0);
    @(negedge clk); irq_tim = 1;
    rdchk(12'h344, 32'h0000_0080, "R2 raw timer seen");
    @(negedge clk); irq_tim = 0;
  endtask

  task automatic t_priority;
    wr(12'h304, 32'h888); wr(12'h300, 32'h0);
    @(negedge clk); irq_sw = 1; irq_tim = 1; irq_ext = 1;
    #1 chk("R4 gated by global enable", {31'h0, irq_take}, 32'h0);
    wr(12'h300, 32'h8);
    #1 chk("R4 ext wins", {irq_take, 26'h0, irq_cause}, 32'h8000_000B);
    @(negedge clk); irq_ext = 0;
    #1 chk("R4 sw over timer", {irq_take, 26'h0, irq_cause}, 32'h8000_0003);
    @(negedge clk); irq_sw = 0;
    #1 chk("R4 timer alone", {irq_take, 26'h0, irq_cause}, 32'h8000_0007);
    @(negedge clk); irq_tim = 0;
    #1 chk("R4 none pending", {31'h0, irq_take}, 32'h0);
  endtask

  task automatic t_exception;
    wr(12'h305, 32'hFFFF_FF03);
    rdchk(12'h305, 32'hFFFF_FF01, "R11 vector bit1 zero");
    wr(12'h305, 32'h0000_1002);
    rdchk(12'h305, 32'h0000_1000, "R11 vector readback");
    wr(12'h300, 32'h8);
    raise_exc(5'd5, 32'h200, 32'h0, 32'h1000, "R5 R11 exc base");
    rdchk(12'h341, 32'h200, "R5 saved pc");
    rdchk(12'h342, 32'h5, "R5 cause");
    rdchk(12'h300, 32'h1880, "R9 status after entry");
  endtask

  task automatic t_tval_illegal;
    raise_exc(5'd2, 32'h300, 32'hABCD_1234, 32'h1000, "R7 short");
    rdchk(12'h343, 32'h0000_1234, "R7 compressed truncated");
    raise_exc(5'd2, 32'h304, 32'h1234_5673, 32'h1000, "R7 full");
    rdchk(12'h343, 32'h1234_5673, "R7 full word kept");
  endtask

  task automatic t_fault_record;
    @(negedge clk); fault_rec_valid = 1; fault_rec_addr = 32'hDEAD_0000;
    @(negedge clk); fault_rec_valid = 0;
    raise_exc(5'd5, 32'h400, 32'h0, 32'h1000, "R8 first");
    rdchk(12'h343, 32'hDEAD_0000, "R8 recorded address");
    raise_exc(5'd7, 32'h404, 32'h0, 32'h1000, "R8 second");
    rdchk(12'h343, 32'h0, "R8 record cleared");
  endtask

  task automatic t_irq_and_return;
    wr(12'h305, 32'h0000_2001); wr(12'h304, 32'h888); wr(12'h300, 32'h8);
    @(negedge clk); irq_tim = 1;
    #1 chk("R4 timer offered", {irq_take, 26'h0, irq_cause}, 32'h8000_0007);
    @(negedge clk); irq_ack = 1; irq_next_pc = 32'h404;
    #1 chk("R6 vectored redirect", redirect_pc, 32'h0000_201C);
    @(negedge clk); irq_ack = 0;
    #1 chk("R9 take dropped after entry", {31'h0, irq_take}, 32'h0);
    rdchk(12'h342, 32'h8000_0007, "R6 irq cause");
    rdchk(12'h341, 32'h404, "R6 saved next pc");
    rdchk(12'h300, 32'h1880, "R9 status after irq");
    @(negedge clk); mret = 1;
    #1 chk("R10 return redirect", redirect_pc, 32'h404);
    @(negedge clk); mret = 0;
    #1 chk("R10 take again at once", {irq_take, 26'h0, irq_cause}, 32'h8000_0007);
    rdchk(12'h300, 32'h1888, "R10 status restored");
    wr(12'h300, 32'h1800);
    @(negedge clk); mret = 1;
    @(negedge clk); mret = 0;
    rdchk(12'h300, 32'h1880, "R10 pgie set gie from zero");
    wr(12'h305, 32'h0000_2000); wr(12'h300, 32'h8);
    @(negedge clk); irq_ack = 1; irq_next_pc = 32'h500;
    #1 chk("R6 direct redirect", redirect_pc, 32'h0000_2000);
    @(negedge clk); irq_ack = 0; irq_tim = 0;
    @(negedge clk); irq_ack = 1;
    #1 chk("R6 ack ignored without take", {31'h0, redirect_valid}, 32'h0);
    @(negedge clk); irq_ack = 0;
    rdchk(12'h341, 32'h500, "R6 ignored ack left saved pc");
  endtask

  task automatic t_collisions;
    wr(12'h305, 32'h0000_3000); wr(12'h304, 32'h888); wr(12'h300, 32'h8);
    @(negedge clk); irq_ext = 1;
    @(negedge clk);
    exc_valid = 1; exc_cause = 5'd4; exc_pc = 32'h600;
    irq_ack = 1; irq_next_pc = 32'h900;
    csr_en = 1; csr_we = 1; csr_addr = 12'h341; csr_wdata = 32'h0000_AAAA;
    #1 chk("R12 exception redirect wins", redirect_pc, 32'h0000_3000);
    @(negedge clk); exc_valid = 0; irq_ack = 0; csr_en = 0; csr_we = 0; irq_ext = 0;
    rdchk(12'h342, 32'h4, "R12 exception cause wins");
    rdchk(12'h341, 32'h600, "R12 trap beats csr write");
  endtask

  task automatic t_scratch;
    wr(12'h340, 32'h1234_5678);
    rdchk(12'h340, 32'h1234_5678, "R13 scratch");
  endtask

  task automatic finish_run;
    if (!done) begin
      done = 1;
      $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
      $finish;
    end
  endtask

  initial begin
    repeat (40000) @(posedge clk);
    n_chk++; n_bad++;
    $display("FAIL watchdog all requirements actual=timeout expected=completion");
    finish_run();
  end

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1;
    t_reset();
    t_status_mask();
    t_ids();
    t_irq_regs();
    t_priority();
    t_exception();
    t_tval_illegal();
    t_fault_record();
    t_irq_and_return();
    t_collisions();
    t_scratch();
    finish_run();
  end
endmodule